// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter assembled from identical 4-bit slices. Each slice counts in plain binary modulo 16 and can be preset from a parallel data word. It has two count-enable inputs: a wide one that gates only the increment, and a chain one that gates both the increment and the slice's terminal-count flag. The top level chains a parameterised number of slices into one wider counter. The carry uses a lookahead arrangement: the terminal count of slice 0 drives the wide enable of every higher slice, and each slice's terminal count drives the chain enable of the slice above it. This keeps the carry path short, because a higher slice only waits on slice 0 and on a ripple that has 16 cycles to settle.

At the top level, one global count enable drives both enables of slice 0. An active-low asynchronous reset clears the counter. An active-low load strobe presets every slice on the next rising edge. The concatenated count is presented with slice 0 as the least significant nibble. The terminal count of every slice is brought out, and the last one doubles as the whole counter's terminal count. The block has no data stream, so every pin is a plain level-sensitive control or status signal.

Top module: `casc_bin_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 and every bit of `stage_tc` and `tc_out` is 0. This holds at once, without a clock edge, and overrides `load_n`, `cnt_en` and `din`.
- R2: With `rst_n` high and `load_n` low, `count` takes the value of `din` on the next rising edge, whether `cnt_en` is 0 or 1.
- R3: With `rst_n` and `load_n` high and `cnt_en` high, `count` rises by exactly one on each rising edge. From all ones it steps to 0.
- R4: With `rst_n` and `load_n` high and `cnt_en` low, `count` keeps its value across rising edges.
- R5: Each 4-bit slice steps from 15 to 0. On the same edge, the next slice up rises by one, so carries cross slice boundaries with no lag.
- R6: `stage_tc[k]` is 1 exactly when `cnt_en` is 1 and slices 0 through k all hold 15. It does not depend on `load_n`.
- R7: `tc_out` equals `stage_tc[NSTAGE-1]`. It is 1 exactly when `count` is all ones and `cnt_en` is 1, whatever the value of `load_n`.
- R8: Apart from reset, `count` changes only at a rising clock edge. A change of `load_n`, `cnt_en` or `din` between edges leaves `count` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous preset strobe, active low |
| cnt_en | input | 1 | Global count enable, feeds both enables of slice 0 |
| din | input | 4*NSTAGE | Preset value, slice 0 in bits 3:0 |
| count | output | 4*NSTAGE | Counter value, slice 0 in bits 3:0 |
| stage_tc | output | NSTAGE | Terminal count of each slice |
| tc_out | output | 1 | Terminal count of the whole counter |

## Verification
Each slice carries assertions that run on every cycle: the load result one edge later, the increment and the 15-to-0 wrap, the hold when either enable is low, and a zero count while reset is held. The top level adds assertions on every cycle for the carry into each higher slice and for the stability of a slice whose lower slices are not all ones. The bench's scenarios are needed for the rest. These cover the asynchronous clear taking effect between edges, terminal-count values under different load and enable settings, the full-width wrap, and a mid-cycle input change that must not disturb the count.

// File: rtl/casc_cnt_pkg.sv
package casc_cnt_pkg;
  localparam int unsigned NIB_W = 4;
  typedef logic [NIB_W-1:0] nibble_t;
  localparam nibble_t NIB_MAX = '1;
endpackage

// File: rtl/cnt_nibble_stage.sv
module cnt_nibble_stage
  import casc_cnt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pe_n,
  input  logic    en_wide,
  input  logic    en_chain,
  input  nibble_t d,
  output nibble_t q,
  output logic    tc
);

  logic step;

  assign step = pe_n & en_wide & en_chain;
  assign tc   = en_chain & (q == NIB_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (!pe_n) q <= d;
    else if (step)  q <= q + 1'b1;
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) !rst_n |-> (q == '0));

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pe_n |=> (q == $past(d)));

  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_n && en_wide && en_chain) |=> (q == nibble_t'($past(q) + 1'b1)));

  // R5
  nib_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_n && en_wide && en_chain && q == NIB_MAX) |=> (q == '0));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_n && !(en_wide && en_chain)) |=> $stable(q));

endmodule

// File: rtl/casc_bin_counter.sv
module casc_bin_counter
  import casc_cnt_pkg::*;
#(
  parameter int unsigned NSTAGE = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_n,
  input  logic                    cnt_en,
  input  logic [NSTAGE*NIB_W-1:0] din,
  output logic [NSTAGE*NIB_W-1:0] count,
  output logic [NSTAGE-1:0]       stage_tc,
  output logic                    tc_out
);

  localparam int unsigned TOT_W = NSTAGE * NIB_W;

  for (genvar k = 0; k < NSTAGE; k++) begin : g_slice
    logic wide_k, chain_k;
    if (k == 0) begin : g_first
      assign wide_k  = cnt_en;
      assign chain_k = cnt_en;
    end else begin : g_upper
      assign wide_k  = stage_tc[0];
      assign chain_k = stage_tc[k-1];
    end

    cnt_nibble_stage u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .pe_n     (load_n),
      .en_wide  (wide_k),
      .en_chain (chain_k),
      .d        (din[k*NIB_W +: NIB_W]),
      .q        (count[k*NIB_W +: NIB_W]),
      .tc       (stage_tc[k])
    );

    if (k > 0) begin : g_carry_chk
      // R5
      carry_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en && count[k*NIB_W-1:0] == '1)
        |=> (count[k*NIB_W +: NIB_W] == nibble_t'($past(count[k*NIB_W +: NIB_W]) + 1'b1)));

      // R5
      no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && count[k*NIB_W-1:0] != '1)
        |=> $stable(count[k*NIB_W +: NIB_W]));
    end
  end

  assign tc_out = stage_tc[NSTAGE-1];

  // R7
  full_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out |-> (count == {TOT_W{1'b1}} && cnt_en));

endmodule

// File: tb/casc_bin_counter_tb_top.sv
module casc_bin_counter_tb_top;
  localparam int NST   = 3;
  localparam int TW    = NST * 4;
  localparam int CLK_T = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic load_n = 1'b1;
  logic cnt_en = 1'b0;
  logic [TW-1:0] din = '0;
  logic [TW-1:0] count;
  logic [NST-1:0] stage_tc;
  logic tc_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [TW-1:0] mdl;

  casc_bin_counter #(.NSTAGE(NST)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en(cnt_en),
    .din(din), .count(count), .stage_tc(stage_tc), .tc_out(tc_out)
  );

  always #(CLK_T/2) clk = ~clk;

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mdl <= '0;
    else if (!load_n) mdl <= din;
    else if (cnt_en)  mdl <= mdl + 1'b1;
  end

  function automatic logic [NST-1:0] exp_tc(input logic [TW-1:0] v, input logic en, input logic rn);
    logic acc;
    logic [NST-1:0] r;
    acc = en & rn;
    for (int k = 0; k < NST; k++) begin
      acc = acc & (v[k*4 +: 4] == 4'hF);
      r[k] = acc;
    end
    return r;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [NST-1:0] et;
    et = exp_tc(mdl, cnt_en, rst_n);
    chk(cur_req, "count", count, mdl);
    chk("R6", "stage_tc", stage_tc, et);
    chk("R7", "tc_out", tc_out, et[NST-1]);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    // R1: reset overrides load and count
    cur_req = "R1";
    load_n = 1'b0; cnt_en = 1'b1; din = 12'hA5C;
    cyc(3);
    chk("R1", "count in reset", count, 0);
    rst_n = 1'b1; load_n = 1'b1; cnt_en = 1'b1;
    // R3: plain counting from zero
    cur_req = "R3";
    cyc(5);
    chk("R3", "count after 5", count, 5);
    // R5: carry over slice boundaries
    cur_req = "R5";
    load_n = 1'b0; din = 12'h0FD;
    cyc(1);
    load_n = 1'b1;
    cyc(4);
    chk("R5", "carry into slice 2", count, 12'h101);
    // R4: hold with cnt_en low, TC gated by enable (R6)
    cur_req = "R4";
    load_n = 1'b0; din = 12'h0FF; cnt_en = 1'b0;
    cyc(1);
    load_n = 1'b1;
    cyc(4);
    chk("R4", "held value", count, 12'h0FF);
    chk("R6", "tc low when disabled", stage_tc, 0);
    cnt_en = 1'b1;
    #1 chk("R6", "tc of slices 0,1", stage_tc, 3'b011);
    cyc(1);
    // R2: load regardless of cnt_en
    cur_req = "R2";
    load_n = 1'b0; din = 12'h3C7; cnt_en = 1'b0;
    cyc(1);
    chk("R2", "load with en low", count, 12'h3C7);
    din = 12'h81E; cnt_en = 1'b1;
    cyc(1);
    chk("R2", "load with en high", count, 12'h81E);
    // R7: full wrap and tc independent of load_n
    cur_req = "R3";
    din = 12'hFFD;
    cyc(1);
    load_n = 1'b1;
    cyc(2);
    chk("R7", "tc_out at all ones", tc_out, 1);
    load_n = 1'b0; din = 12'hFFF;
    #1 chk("R7", "tc_out with load_n low", tc_out, 1);
    load_n = 1'b1;
    cyc(1);
    chk("R3", "wrap to zero", count, 0);
    chk("R7", "tc_out after wrap", tc_out, 0);
    // R8: mid-cycle input change leaves count unchanged
    cur_req = "R8";
    cyc(3);
    load_n = 1'b0; din = 12'h555; cnt_en = 1'b0;
    #2 chk("R8", "count between edges", count, 3);
    cyc(1);
    load_n = 1'b1; cnt_en = 1'b1;
    cyc(20);
    // R1: asynchronous clear between edges
    cur_req = "R1";
    load_n = 1'b0; din = 12'hFFF;
    cyc(1);
    load_n = 1'b1;
    #1 rst_n = 1'b0;
    #1 chk("R1", "async clear count", count, 0);
    chk("R1", "async clear tc", {stage_tc, tc_out}, 0);
    cyc(2);
    rst_n = 1'b1;
    cur_req = "R3";
    cyc(300);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_T * 200000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule